// File: doc/BRIEF.md
# Frame-to-Spike Event Generator

This block turns a stored grayscale picture into a stream of pixel address events, the way a spiking image sensor reports activity. It keeps a 64 by 64 frame of 8-bit intensities and sweeps the pixels in ascending address order, one pixel per clock. At each pixel the intensity is compared with the current value of a pseudo-random shift register. When the intensity wins, the block raises an event that carries the pixel address. Bright pixels therefore win often and dark pixels rarely. Because the random value changes at every step, each pixel's event train is irregular, with roughly Poisson spacing, and not periodic.

Frame memory has two banks. The host fills the bank that is not being scanned through a plain write port, then pulses a swap strobe. The swap takes effect at the end of the sweep in progress, so a new picture (one every 40 ms at 25 frames per second) always replaces the old one on a scan boundary. Events leave through a four-phase request/acknowledge port. While a request is outstanding the sweep is frozen, so a slow receiver only lowers the event rate and never loses or reorders events. With one pixel per cycle and a short handshake, a 100 MHz clock allows the 10^7 events per second peak.

Top module: `spike_event_gen`

## Requirements
- R1: The event address is 12 bits. Row is in bits [11:6] and column is in bits [5:0], so the address equals row*64+col of the pixel that fired.
- R2: The random source is an 8-bit register reset to the seed 8'hA5. Its next state is {s[6:0], s[7]^s[5]^s[4]^s[3]}, a maximal-length sequence that never reaches zero. It advances exactly once per pixel visited and holds while the sweep is stalled.
- R3: A visited pixel fires when its intensity is strictly greater than the random value of that step. Intensity 0 never fires, and neither does intensity 1, because the register is never zero. A brighter pixel fires more often than a dimmer one.
- R4: The sweep visits addresses 0,1,...,4095 in ascending order and then wraps to 0, one pixel per clock while no request is outstanding. It stays frozen while an event is in flight.
- R5: The request rises with the address already valid. The request and the address stay unchanged until acknowledge is seen high. The request then falls, and the next pixel is not visited until acknowledge is seen low.
- R6: Writes always land in the bank that is not being scanned, and they never change the events taken from the scanned bank.
- R7: After reset no bank is scanned and no event is produced. The first swap strobe takes effect on the next clock. The sweep then starts at pixel 0 with the random value equal to the seed.
- R8: Any later swap strobe takes effect only when pixel 4095 is visited, and this includes a strobe that arrives on that very cycle. A strobe that arrives after that cycle waits for the following scan end.
- R9: During and right after reset, the request is low and the address output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the bank not being scanned |
| wr_addr | input | 12 | Pixel address to write, row in [11:6], column in [5:0] |
| wr_data | input | 8 | Pixel intensity to write |
| swap_req | input | 1 | One-cycle strobe asking to exchange the banks |
| ev_req | output | 1 | Event request, four-phase |
| ev_addr | output | 12 | Address of the pixel that fired |
| ev_ack | input | 1 | Event acknowledge from the receiver |

## Verification
The one collision that decides the outcome is a swap strobe landing on the same clock as the visit of pixel 4095. The bench loads a frame whose only non-zero pixel is 0, and a new frame whose only non-zero pixel is 5. From the release of the handshake on pixel 0 it counts the exact number of clocks to the last-pixel visit and pulses the strobe there. The next event must then come from pixel 5 of the new frame and not from pixel 0 of the old one. A second overlap is checked through the event stream against an independent sweep model: writes to the idle bank and a swap request are issued while an event from the scanned bank is still being held.

// File: rtl/spk_pkg.sv
package spk_pkg;

    localparam int ROW_W  = 6;
    localparam int COL_W  = 6;
    localparam int PIX_W  = 8;
    localparam int N_BANK = 2;

    typedef enum logic [1:0] {
        SC_RUN     = 2'd0,
        SC_HOLD    = 2'd1,
        SC_RELEASE = 2'd2
    } scan_st_e;

    // Fibonacci shift: new bit enters at the bottom, parity of tapped bits.
    function automatic logic [PIX_W-1:0] lfsr_advance(
        input logic [PIX_W-1:0] s,
        input logic [PIX_W-1:0] taps
    );
        return {s[PIX_W-2:0], ^(s & taps)};
    endfunction

endpackage

// File: rtl/spk_lfsr.sv
module spk_lfsr #(
    parameter int                    W    = spk_pkg::PIX_W,
    parameter logic [W-1:0]          SEED = 8'hA5,
    parameter logic [W-1:0]          TAPS = 8'hB8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    output logic [W-1:0] value
);
    always_ff @(posedge clk) begin
        if (rst) begin
            value <= SEED;
        end else if (step) begin
            value <= spk_pkg::lfsr_advance(value, TAPS);
        end
    end

    // R2: a maximal sequence seeded non-zero never reaches the all-zero state
    assert_lfsr_nonzero_R2: assert property (@(posedge clk) disable iff (rst)
        value != '0);

    // R2: the register moves only on a visit step
    assert_lfsr_holds_R2: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(value));
endmodule

// File: rtl/spk_frame_banks.sv
module spk_frame_banks #(
    parameter int AW = spk_pkg::ROW_W + spk_pkg::COL_W,
    parameter int PW = spk_pkg::PIX_W
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic          wr_bank,
    input  logic [AW-1:0] wr_addr,
    input  logic [PW-1:0] wr_data,
    input  logic          rd_bank,
    input  logic [AW-1:0] rd_addr,
    output logic [PW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [PW-1:0] bank_q [spk_pkg::N_BANK];

    for (genvar b = 0; b < spk_pkg::N_BANK; b++) begin : g_bank
        logic [PW-1:0] store [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && (wr_bank == 1'(b))) begin
                store[wr_addr] <= wr_data;
            end
        end

        assign bank_q[b] = store[rd_addr];
    end

    assign rd_data = bank_q[rd_bank];
endmodule

// File: rtl/spk_scan_ctrl.sv
module spk_scan_ctrl #(
    parameter int AW = spk_pkg::ROW_W + spk_pkg::COL_W,
    parameter int PW = spk_pkg::PIX_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] pix,
    input  logic [PW-1:0] rnd,
    input  logic          swap_req,
    input  logic          ev_ack,
    output logic [AW-1:0] rd_addr,
    output logic          step,
    output logic          act_bank,
    output logic          ev_req,
    output logic [AW-1:0] ev_addr
);
    import spk_pkg::*;

    localparam logic [AW-1:0] LAST = '1;

    scan_st_e state;
    logic     loaded;
    logic     swap_pend;
    logic     at_last;
    logic     fire;

    assign step    = loaded && (state == SC_RUN);
    assign at_last = (rd_addr == LAST);
    assign fire    = step && (pix > rnd);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SC_RUN;
            loaded    <= 1'b0;
            swap_pend <= 1'b0;
            act_bank  <= 1'b0;
            rd_addr   <= '0;
            ev_req    <= 1'b0;
            ev_addr   <= '0;
        end else begin
            // bank exchange
            if (!loaded) begin
                if (swap_req) begin
                    loaded    <= 1'b1;
                    act_bank  <= ~act_bank;
                    rd_addr   <= '0;
                    swap_pend <= 1'b0;
                end
            end else if (step && at_last) begin
                if (swap_pend || swap_req) begin
                    act_bank <= ~act_bank;
                end
                swap_pend <= 1'b0;
            end else if (swap_req) begin
                swap_pend <= 1'b1;
            end

            // sweep and handshake
            unique case (state)
                SC_RUN: begin
                    if (step) begin
                        rd_addr <= rd_addr + 1'b1;
                    end
                    if (fire) begin
                        ev_req  <= 1'b1;
                        ev_addr <= rd_addr;
                        state   <= SC_HOLD;
                    end
                end
                SC_HOLD: begin
                    if (ev_ack) begin
                        ev_req <= 1'b0;
                        state  <= SC_RELEASE;
                    end
                end
                SC_RELEASE: begin
                    if (!ev_ack) begin
                        state <= SC_RUN;
                    end
                end
                default: state <= SC_RUN;
            endcase
        end
    end

    // R5: address frozen while the request stays up
    assert_addr_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (ev_req && $past(ev_req)) |-> $stable(ev_addr));

    // R5: request is kept until the receiver acknowledges
    assert_req_until_ack_R5: assert property (@(posedge clk) disable iff (rst)
        (ev_req && !ev_ack) |=> ev_req);

    // R4: sweep position frozen while an event is in flight
    assert_stall_R4: assert property (@(posedge clk) disable iff (rst)
        ev_req |=> $stable(rd_addr));

    // R8: the scanned bank changes only on a scan boundary
    assert_swap_boundary_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(act_bank) |-> (rd_addr == '0));

    // R7: nothing is reported before a frame has been handed over
    assert_quiet_unloaded_R7: assert property (@(posedge clk) disable iff (rst)
        !loaded |-> !ev_req);
endmodule

// File: rtl/spike_event_gen.sv
module spike_event_gen #(
    parameter int                            ROW_W = spk_pkg::ROW_W,
    parameter int                            COL_W = spk_pkg::COL_W,
    parameter int                            PIX_W = spk_pkg::PIX_W,
    parameter logic [spk_pkg::PIX_W-1:0]     SEED  = 8'hA5,
    parameter logic [spk_pkg::PIX_W-1:0]     TAPS  = 8'hB8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [ROW_W+COL_W-1:0]   wr_addr,
    input  logic [PIX_W-1:0]         wr_data,
    input  logic                     swap_req,
    output logic                     ev_req,
    output logic [ROW_W+COL_W-1:0]   ev_addr,
    input  logic                     ev_ack
);
    localparam int AW = ROW_W + COL_W;

    logic [AW-1:0]    scan_addr;
    logic [PIX_W-1:0] scan_pix;
    logic [PIX_W-1:0] rnd;
    logic             step;
    logic             act_bank;

    spk_frame_banks #(.AW(AW), .PW(PIX_W)) u_banks (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_bank (~act_bank),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_bank (act_bank),
        .rd_addr (scan_addr),
        .rd_data (scan_pix)
    );

    spk_lfsr #(.W(PIX_W), .SEED(SEED), .TAPS(TAPS)) u_lfsr (
        .clk   (clk),
        .rst   (rst),
        .step  (step),
        .value (rnd)
    );

    spk_scan_ctrl #(.AW(AW), .PW(PIX_W)) u_scan (
        .clk      (clk),
        .rst      (rst),
        .pix      (scan_pix),
        .rnd      (rnd),
        .swap_req (swap_req),
        .ev_ack   (ev_ack),
        .rd_addr  (scan_addr),
        .step     (step),
        .act_bank (act_bank),
        .ev_req   (ev_req),
        .ev_addr  (ev_addr)
    );
endmodule

// File: tb/tb_spike_event_gen.sv
module tb_spike_event_gen;
    localparam int         CLK_PERIOD = 10;
    localparam int         NPIX       = 4096;
    localparam logic [7:0] SEED       = 8'hA5;
    localparam int         NVEC       = 10;
    // frame id, pixel address, intensity
    localparam int VEC [NVEC][3] = '{
        '{0, 0,    255}, '{0, 199,  200}, '{0, 4095, 255}, '{0, 10,   0},
        '{0, 64,   128}, '{0, 2000, 16},  '{0, 3000, 1},   '{0, 4032, 90},
        '{1, 0,    255}, '{2, 5,    255}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [11:0] wr_addr;
    logic [7:0]  wr_data;
    logic        swap_req;
    logic        ev_req;
    logic [11:0] ev_addr;
    logic        ev_ack;

    int n_chk = 0;
    int n_bad = 0;

    // sweep model
    logic [7:0] m_mem [2][NPIX];
    int         m_act;
    int         m_ptr;
    bit         m_pend;
    logic [7:0] m_lf;

    always #(CLK_PERIOD/2) clk = ~clk;

    spike_event_gen dut (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .swap_req (swap_req),
        .ev_req   (ev_req),
        .ev_addr  (ev_addr),
        .ev_ack   (ev_ack)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] lf_next(input logic [7:0] s);
        return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction

    task automatic predict(output int a);
        a = -1;
        for (int i = 0; i < NPIX * 8; i++) begin
            bit win;
            int here;
            here  = m_ptr;
            win   = m_mem[m_act][m_ptr] > m_lf;
            m_lf  = lf_next(m_lf);
            if (m_ptr == NPIX - 1) begin
                m_ptr = 0;
                if (m_pend) begin
                    m_act  = m_act ^ 1;
                    m_pend = 1'b0;
                end
            end else begin
                m_ptr = m_ptr + 1;
            end
            if (win) begin
                a = here;
                break;
            end
        end
    endtask

    task automatic load_frame(input int fid);
        logic [7:0] img [NPIX];
        for (int a = 0; a < NPIX; a++) img[a] = 8'd0;
        for (int v = 0; v < NVEC; v++) begin
            if (VEC[v][0] == fid) img[VEC[v][1]] = 8'(VEC[v][2]);
        end
        for (int a = 0; a < NPIX; a++) begin
            @(negedge clk);
            wr_en   = 1'b1;
            wr_addr = 12'(a);
            wr_data = img[a];
            m_mem[m_act ^ 1][a] = img[a];
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic take_event(input bit do_swap, output int got);
        int w;
        int exp;
        w = 0;
        while (!ev_req && w < 3 * NPIX) begin
            @(negedge clk);
            w++;
        end
        if (!ev_req) begin
            check("R5 request never raised", 0, 1);
            got = -1;
            return;
        end
        predict(exp);
        got = int'(ev_addr);
        check("R1 R3 R4 event address", got, exp);
        if (got == 199) begin
            check("R1 row field", int'(ev_addr[11:6]), 3);
            check("R1 column field", int'(ev_addr[5:0]), 7);
        end
        repeat (2) @(negedge clk);
        if (do_swap) begin
            swap_req = 1'b1;
            m_pend   = 1'b1;
            @(negedge clk);
            swap_req = 1'b0;
        end
        @(negedge clk);
        check("R5 request held before ack", int'(ev_req), 1);
        check("R5 address held before ack", int'(ev_addr), got);
        ev_ack = 1'b1;
        do @(negedge clk); while (ev_req);
        ev_ack = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int got;
        int c_hi, c_lo, c_zero, c_one;
        int seen;
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        swap_req = 1'b0; ev_ack = 1'b0;
        m_act = 0; m_ptr = 0; m_pend = 1'b0; m_lf = SEED;
        for (int a = 0; a < NPIX; a++) begin
            m_mem[0][a] = 8'd0;
            m_mem[1][a] = 8'd0;
        end
        repeat (4) @(negedge clk);
        check("R9 request in reset", int'(ev_req), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R9 request after reset", int'(ev_req), 0);
        check("R9 address after reset", int'(ev_addr), 0);

        // R7: quiet before any frame is handed over
        seen = 0;
        repeat (300) begin
            @(negedge clk);
            if (ev_req) seen++;
        end
        check("R7 no events before first swap", seen, 0);

        // first frame, then immediate swap
        load_frame(0);
        check("R7 no events while first frame loads", int'(ev_req), 0);
        swap_req = 1'b1;
        @(negedge clk);
        swap_req = 1'b0;
        m_act = m_act ^ 1; m_ptr = 0; m_lf = SEED;
        @(negedge clk);
        check("R7 pixel 0 fires right after first swap", int'(ev_req), 1);
        check("R7 first event is pixel 0", int'(ev_addr), 0);

        // main vector walk over the event stream
        c_hi = 0; c_lo = 0; c_zero = 0; c_one = 0;
        for (int k = 0; k < 30; k++) begin
            take_event(1'b0, got);
            if (got == 4095) c_hi++;
            if (got == 2000) c_lo++;
            if (got == 10)   c_zero++;
            if (got == 3000) c_one++;
        end
        check("R3 bright pixel fires more than dim pixel", int'(c_hi > c_lo), 1);
        check("R3 intensity 0 never fires", c_zero, 0);
        check("R3 intensity 1 never fires", c_one, 0);

        // R6: refill the idle bank while the scanned one keeps producing
        load_frame(1);
        // R8: swap requested mid-scan while an event is held
        take_event(1'b1, got);
        for (int k = 0; k < 40; k++) begin
            if (m_act == 0 && got == 0) break;
            take_event(1'b0, got);
        end
        check("R8 swap applied at scan end", m_act, 0);

        // R6: write the idle bank during scanning of the new frame
        load_frame(2);
        take_event(1'b0, got);
        check("R6 scanned bank unaffected by writes", got, 0);

        // R8: strobe exactly on the cycle pixel 4095 is visited
        repeat (4095 - got) @(negedge clk);
        swap_req = 1'b1;
        m_pend   = 1'b1;
        @(negedge clk);
        swap_req = 1'b0;
        take_event(1'b0, got);
        check("R8 same-cycle strobe swaps at this scan end", got, 5);
        take_event(1'b0, got);
        check("R8 new frame stays active", got, 5);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule